// File: doc/BRIEF.md
# Three-Aspect Signal Head Sequencer

This block drives the red, amber and green lamps of one signal head through a fixed cycle of four phases. A 2-bit phase code is first expanded into four phase lines, and the three lamps are then formed from those lines. The four phases are red alone, red with amber, green alone and amber alone. Red and amber therefore show together just before green, and amber shows alone just before red.

In counting mode the block keeps the phase code itself. Each clock edge that sees the advance strobe high moves the phase forward by one step and wraps from the last phase back to the first. In one-hot mode the phase comes straight from four external phase lines. A malformed pattern on those lines puts the head into a safe all-red state and raises a fault flag.

Every output is held in a flip-flop, so the lamps change cleanly at a clock edge. Reset is synchronous and active low.

Top module: `sig_head_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are phase code 0, red on, amber off, green off and fault off.
- R2: The lamps follow the phase code. Code 0 gives red only, code 1 gives red and amber, code 2 gives green only and code 3 gives amber only. At every moment exactly this pattern is shown for the current `phase_o`.
- R3: In counting mode (`onehot_mode_i` = 0), a clock edge with `step_i` high moves the phase code from n to n+1. Code 3 wraps to code 0.
- R4: In counting mode, a clock edge with `step_i` low leaves the phase code and the lamps unchanged.
- R5: In one-hot mode (`onehot_mode_i` = 1), if exactly bit n of `phase_sel_i` is 1, the next phase code is n and the fault flag is off. `step_i` has no effect in this mode.
- R6: In one-hot mode, a `phase_sel_i` with no bit set or with more than one bit set is invalid. The next phase code is 0, only red is lit, and `fault_o` is 1.
- R7: All outputs are registered. A change on any input is not visible on the outputs before the next rising clock edge.
- R8: On the first edge after the mode returns to counting, `fault_o` is cleared. Counting then continues from the phase held in the phase register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Advance strobe, used in counting mode |
| onehot_mode_i | input | 1 | 0 selects counting mode, 1 selects one-hot mode |
| phase_sel_i | input | 4 | One-hot phase lines; bit n selects phase n |
| lamp_red_o | output | 1 | Red lamp on |
| lamp_amber_o | output | 1 | Amber lamp on |
| lamp_green_o | output | 1 | Green lamp on |
| phase_o | output | 2 | Current phase code |
| fault_o | output | 1 | Invalid one-hot pattern seen at the last edge |

## Verification
The assertions assume that the inputs are stable around each rising edge and never carry X or Z values. The one-hot properties also assume that the mode input reflects the intended source at the edge where it is sampled. The stimulus changes every input only on falling edges, and it drives defined values from time zero, including during reset. This keeps each edge's decision unambiguous. The stimulus walks every valid one-hot line and several invalid patterns (none set, two set, all set). It switches modes in both directions, and it applies a reset in the middle of a sequence.

// File: rtl/sig_head_pkg.sv
// Shared widths and types for the signal head sequencer.
// Assumes a fixed four-phase cycle addressed by a 2-bit code.
package sig_head_pkg;
    localparam int PHASE_W = 2;
    localparam int N_PHASE = 1 << PHASE_W;

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [N_PHASE-1:0] lines_t;

    // Lamp drive bundle, one bit per aspect.
    typedef struct packed {
        logic red;
        logic amber;
        logic green;
    } lamp_t;

    localparam phase_t PH_STOP  = 2'd0;
    localparam phase_t PH_READY = 2'd1;
    localparam phase_t PH_GO    = 2'd2;
    localparam phase_t PH_CLEAR = 2'd3;
endpackage

// File: rtl/phase_decode.sv
// Expands a binary phase code into one-hot phase lines.
// Assumes the code is always in range, which holds for any 2-bit value.
module phase_decode
    import sig_head_pkg::*;
#(
    parameter int CODE_W = PHASE_W,
    localparam int N_LINE = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [N_LINE-1:0] lines_o
);
    // One comparator per line, each matching a single code value.
    for (genvar g = 0; g < N_LINE; g++) begin : g_line
        assign lines_o[g] = (code_i == CODE_W'(g));
    end
endmodule

// File: rtl/lamp_form.sv
// Forms the three lamp drives from the four phase lines.
// Assumes at most one line is high, which the decoder guarantees.
module lamp_form
    import sig_head_pkg::*;
(
    input  lines_t lines_i,
    output lamp_t  lamp_o
);
    // Each lamp is the OR of the phases in which it is lit.
    always_comb begin
        lamp_o.red   = lines_i[PH_STOP]  | lines_i[PH_READY];
        lamp_o.amber = lines_i[PH_READY] | lines_i[PH_CLEAR];
        lamp_o.green = lines_i[PH_GO];
    end
endmodule

// File: rtl/onehot_check.sv
// Checks the external phase lines and encodes a valid one-hot value.
// Assumes the lines carry no X; the encoded value is only used when valid_o is 1.
module onehot_check
    import sig_head_pkg::*;
#(
    parameter int N_LINE = N_PHASE,
    localparam int CODE_W = $clog2(N_LINE)
) (
    input  logic [N_LINE-1:0] sel_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);
    // A pattern is valid only if exactly one line is set.
    always_comb valid_o = ($countones(sel_i) == 1);

    // OR together the index of every set line; this is exact when one is set.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < N_LINE; i++) begin
            if (sel_i[i]) code_o = code_o | CODE_W'(i);
        end
    end
endmodule

// File: rtl/phase_next.sv
// Chooses the phase for the next edge and says whether it will be a fault.
// Assumes valid_i and enc_i come from onehot_check on the same cycle.
module phase_next
    import sig_head_pkg::*;
(
    input  phase_t cur_i,
    input  logic   step_i,
    input  logic   onehot_mode_i,
    input  logic   valid_i,
    input  phase_t enc_i,
    output phase_t nxt_o,
    output logic   fault_o
);
    // Counting mode steps or holds; one-hot mode takes the lines or falls back to red.
    always_comb begin
        fault_o = 1'b0;
        if (onehot_mode_i) begin
            if (valid_i) begin
                nxt_o = enc_i;
            end else begin
                nxt_o   = PH_STOP;
                fault_o = 1'b1;
            end
        end else if (step_i) begin
            nxt_o = cur_i + phase_t'(1);
        end else begin
            nxt_o = cur_i;
        end
    end
endmodule

// File: rtl/sig_head_seq.sv
// Top of the signal head sequencer: phase register, decode and lamp registers.
// Lamps are formed from the next phase and registered with it, so that
// phase, lamps and fault all change on the same edge and lamps never glitch.
// Assumes inputs are synchronous to clk. Reset is synchronous and active low.
module sig_head_seq
    import sig_head_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       onehot_mode_i,
    input  logic [3:0] phase_sel_i,
    output logic       lamp_red_o,
    output logic       lamp_amber_o,
    output logic       lamp_green_o,
    output logic [1:0] phase_o,
    output logic       fault_o
);
    phase_t phase_q;
    phase_t phase_d;
    phase_t enc;
    logic   sel_valid;
    logic   fault_d;
    logic   fault_q;
    lines_t lines_d;
    lamp_t  lamp_d;
    lamp_t  lamp_q;

    onehot_check #(.N_LINE(N_PHASE)) u_oh (
        .sel_i   (phase_sel_i),
        .valid_o (sel_valid),
        .code_o  (enc)
    );

    phase_next u_nxt (
        .cur_i         (phase_q),
        .step_i        (step_i),
        .onehot_mode_i (onehot_mode_i),
        .valid_i       (sel_valid),
        .enc_i         (enc),
        .nxt_o         (phase_d),
        .fault_o       (fault_d)
    );

    phase_decode #(.CODE_W(PHASE_W)) u_dec (
        .code_i  (phase_d),
        .lines_o (lines_d)
    );

    lamp_form u_lamp (
        .lines_i (lines_d),
        .lamp_o  (lamp_d)
    );

    // Output registers: phase, lamps and fault, with reset to red.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_STOP;
            lamp_q  <= '{red: 1'b1, amber: 1'b0, green: 1'b0};
            fault_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            lamp_q  <= lamp_d;
            fault_q <= fault_d;
        end
    end

    assign phase_o      = phase_q;
    assign lamp_red_o   = lamp_q.red;
    assign lamp_amber_o = lamp_q.amber;
    assign lamp_green_o = lamp_q.green;
    assign fault_o      = fault_q;
endmodule

// File: rtl/sig_head_seq_chk.sv
// Property checker for sig_head_seq, attached with bind below.
// Assumes inputs hold defined values at every rising edge.
module sig_head_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step_i,
    input logic       onehot_mode_i,
    input logic [3:0] phase_sel_i,
    input logic       lamp_red_o,
    input logic       lamp_amber_o,
    input logic       lamp_green_o,
    input logic [1:0] phase_o,
    input logic       fault_o
);
    AST_RESET_RED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (phase_o == 2'd0 && lamp_red_o && !lamp_amber_o && !lamp_green_o && !fault_o)); // R1

    AST_LAMP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_red_o == (phase_o == 2'd0 || phase_o == 2'd1)) &&
        (lamp_amber_o == (phase_o == 2'd1 || phase_o == 2'd3)) &&
        (lamp_green_o == (phase_o == 2'd2))); // R2

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!onehot_mode_i && step_i) |=> (phase_o == $past(phase_o) + 2'd1)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!onehot_mode_i && !step_i) |=> ($stable(phase_o) && $stable(lamp_red_o) &&
                                         $stable(lamp_amber_o) && $stable(lamp_green_o))); // R4

    AST_ONEHOT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (onehot_mode_i && $onehot(phase_sel_i)) |=>
            (!fault_o && ((($past(phase_sel_i)) >> phase_o) & 4'd1) == 4'd1)); // R5

    AST_BAD_SEL_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (onehot_mode_i && !$onehot(phase_sel_i)) |=>
            (fault_o && phase_o == 2'd0 && lamp_red_o && !lamp_amber_o && !lamp_green_o)); // R6

    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !onehot_mode_i |=> !fault_o); // R8
endmodule

bind sig_head_seq sig_head_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_i        (step_i),
    .onehot_mode_i (onehot_mode_i),
    .phase_sel_i   (phase_sel_i),
    .lamp_red_o    (lamp_red_o),
    .lamp_amber_o  (lamp_amber_o),
    .lamp_green_o  (lamp_green_o),
    .phase_o       (phase_o),
    .fault_o       (fault_o)
);

// File: tb/sig_head_seq_tb.sv
module sig_head_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_i = 1'b0;
    logic       onehot_mode_i = 1'b0;
    logic [3:0] phase_sel_i = 4'b0000;
    logic       lamp_red_o, lamp_amber_o, lamp_green_o, fault_o;
    logic [1:0] phase_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Behavioural reference state.
    int ref_phase = 0;
    bit ref_fault = 1'b0;

    always #5 clk = ~clk;

    sig_head_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_i        (step_i),
        .onehot_mode_i (onehot_mode_i),
        .phase_sel_i   (phase_sel_i),
        .lamp_red_o    (lamp_red_o),
        .lamp_amber_o  (lamp_amber_o),
        .lamp_green_o  (lamp_green_o),
        .phase_o       (phase_o),
        .fault_o       (fault_o)
    );

    function automatic int count_set(logic [3:0] v);
        int c = 0;
        for (int i = 0; i < 4; i++) if (v[i]) c++;
        return c;
    endfunction

    function automatic int first_set(logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return 0;
    endfunction

    // Reference model update, one step per rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ref_phase = 0;
            ref_fault = 1'b0;
        end else if (onehot_mode_i) begin
            if (count_set(phase_sel_i) == 1) begin
                ref_phase = first_set(phase_sel_i);
                ref_fault = 1'b0;
            end else begin
                ref_phase = 0;
                ref_fault = 1'b1;
            end
        end else begin
            ref_fault = 1'b0;
            if (step_i) ref_phase = (ref_phase + 1) % 4;
        end
    end

    function automatic logic [5:0] expect_vec();
        logic r, a, g;
        r = (ref_phase == 0) || (ref_phase == 1);
        a = (ref_phase == 1) || (ref_phase == 3);
        g = (ref_phase == 2);
        return {ref_phase[1:0], r, a, g, ref_fault};
    endfunction

    task automatic compare(string tag);
        logic [5:0] act;
        logic [5:0] exp;
        act = {phase_o, lamp_red_o, lamp_amber_o, lamp_green_o, fault_o};
        exp = expect_vec();
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: {phase,r,a,g,fault} actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    // Drive one cycle: set inputs on the falling edge, check that outputs have
    // not moved yet (R7), then compare after the following rising edge.
    task automatic cycle(input logic rn, input logic st, input logic md,
                         input logic [3:0] sel, input string tag);
        rst_n = rn;
        step_i = st;
        onehot_mode_i = md;
        phase_sel_i = sel;
        #1;
        compare("R7");
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset with noisy inputs.
        cycle(1'b0, 1'b1, 1'b0, 4'b0000, "R1");
        cycle(1'b0, 1'b1, 1'b1, 4'b0100, "R1");
        // R3 and R2: full cycle with wrap.
        for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, 1'b0, 4'b0000, "R3");
        // R4: hold, with the one-hot lines toggling to show they are ignored here.
        cycle(1'b1, 1'b0, 1'b0, 4'b1000, "R4");
        cycle(1'b1, 1'b0, 1'b0, 4'b0001, "R4");
        cycle(1'b1, 1'b1, 1'b0, 4'b0000, "R2");
        cycle(1'b1, 1'b0, 1'b0, 4'b0000, "R4");
        // R5: each valid line, with step high and low.
        for (int n = 3; n >= 0; n--) cycle(1'b1, n[0], 1'b1, 4'b0001 << n, "R5");
        cycle(1'b1, 1'b1, 1'b1, 4'b0100, "R5");
        cycle(1'b1, 1'b1, 1'b1, 4'b0100, "R5");
        // R6: invalid patterns.
        cycle(1'b1, 1'b0, 1'b1, 4'b0000, "R6");
        cycle(1'b1, 1'b0, 1'b1, 4'b1000, "R5");
        cycle(1'b1, 1'b1, 1'b1, 4'b0011, "R6");
        cycle(1'b1, 1'b0, 1'b1, 4'b1111, "R6");
        cycle(1'b1, 1'b0, 1'b1, 4'b1010, "R6");
        // R8: back to counting clears fault and counts on from the held phase.
        cycle(1'b1, 1'b0, 1'b0, 4'b1111, "R8");
        cycle(1'b1, 1'b1, 1'b0, 4'b0000, "R8");
        cycle(1'b1, 1'b1, 1'b1, 4'b0010, "R5");
        cycle(1'b1, 1'b1, 1'b0, 4'b0000, "R8");
        cycle(1'b1, 1'b1, 1'b0, 4'b0000, "R3");
        // R1: reset in mid-sequence, then restart.
        cycle(1'b1, 1'b1, 1'b1, 4'b0000, "R6");
        cycle(1'b0, 1'b1, 1'b1, 4'b0000, "R1");
        cycle(1'b1, 1'b1, 1'b0, 4'b0000, "R3");
        cycle(1'b1, 1'b1, 1'b0, 4'b0000, "R3");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule